// File: doc/BRIEF.md
# Keyed Configuration Register Gate

This block is the configuration front end of a multi-function I/O peripheral. It sits on a simple 8-bit bus that has two ports. Port 0 is the index port and port 1 is the data port. At reset its register file is hidden. Only a fixed two-byte entry key written to the index port opens it. While the gate is open, a write to the index port picks a register and data-port accesses read or write that register. A one-byte exit key closes the gate again.

The register space has two parts. Shared global registers do not depend on the device choice. A logical-device number register selects one of several per-device banks. Each bank holds these registers:

- an activate bit
- three 16-bit base addresses
- an interrupt number and an interrupt type
- two DMA channel bytes
- a mode byte

The contents of every bank are driven out in parallel, so that the sub-devices (outside this block) see their setup directly.

Top module: `keyed_cfg_port`

## Requirements
- R1: After reset the gate is locked, `bus_rdata` is 0xFF, and every per-device output and global register output is 0x00 (all devices inactive).
- R2: The gate opens only after two index-port writes of 0x87 in a row. Any other write between them (an index write of another value, or any data-port write) cancels the partial key, and a new pair is needed.
- R3: While the gate is not open, data-port writes change nothing, index-port writes other than key bytes select nothing, and reads of either port return 0xFF.
- R4: While open, an index-port write of 0xAA closes the gate and clears the index to 0x00. Any other index-port write stores the written value as the index, and an index-port read returns it.
- R5: Index 0x07 holds the logical-device number (all 8 bits, read/write). Banked indices (0x30, 0x60 to 0x65, 0x70, 0x71, 0x74, 0x75, 0xF0) read and write the bank of the selected device only. Other devices are not changed.
- R6: At index 0x30 only bit 0 is stored. It reads back as {7'b0, bit0} and drives that device's `dev_enable` bit.
- R7: Each base address is a high byte at an even index and a low byte at the next odd index: 0x60/0x61 go to `dev_base0`, 0x62/0x63 go to `dev_base1`, and 0x64/0x65 go to `dev_base2`. Each is output as {high, low}.
- R8: Index 0x70 drives `dev_irq`, 0x71 drives `dev_irq_type`, 0x74 drives `dev_dma_rx`, 0x75 drives `dev_dma_tx`, and 0xF0 drives `dev_mode`. Each is stored as a full byte for the selected device.
- R9: Indices 0x20 to 0x2F are global registers, shared by all devices and not banked. A value written with one device selected reads back the same with any other device selected. Global register k drives `glb_regs[8k+7:8k]`.
- R10: A read of an index that is not implemented returns 0xFF, and a write to it has no effect. When the device number is NUM_LDEV or above, banked reads return 0xFF and banked writes are ignored.
- R11: `bus_rdata` changes only in the cycle after a read strobe (`bus_rd` high). At other times it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 1 | Port select: 0 index port, 1 data port |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| cfg_unlocked | output | 1 | High while the gate is open |
| dev_enable | output | NUM_LDEV | Activate bit per device |
| dev_base0 | output | NUM_LDEV*16 | First base address per device |
| dev_base1 | output | NUM_LDEV*16 | Second base address per device |
| dev_base2 | output | NUM_LDEV*16 | Third base address per device |
| dev_irq | output | NUM_LDEV*8 | Interrupt number per device |
| dev_irq_type | output | NUM_LDEV*8 | Interrupt type per device |
| dev_dma_rx | output | NUM_LDEV*8 | Receive DMA channel per device |
| dev_dma_tx | output | NUM_LDEV*8 | Transmit DMA channel per device |
| dev_mode | output | NUM_LDEV*8 | Mode byte per device |
| glb_regs | output | GLB_N*8 | Global registers |

## Verification
The assertions assume that the host never raises `bus_rd` and `bus_wr` in the same cycle. Each strobe is taken to stand for exactly one access. Under that assumption, a read never sees a write to the same register in the same cycle, and a key byte is never counted twice.

The stimulus keeps to this rule because every access comes from a task that raises exactly one strobe for one cycle and then drops it before the next access. Random runs mix the following:

- key entries and exits
- stray key bytes
- device numbers beyond the implemented count
- indices drawn from both the implemented and the unimplemented space

// File: rtl/cfg_gate_pkg.sv
package cfg_gate_pkg;

  localparam int SLOT_N = 12;
  localparam int SLOT_W = 4;

  localparam logic [7:0] KEY_ENTER = 8'h87;
  localparam logic [7:0] KEY_EXIT  = 8'hAA;
  localparam logic [7:0] IDX_LDN   = 8'h07;
  localparam int         GLB_BASE  = 32'h20;

  // bank slot numbering
  localparam int SL_ACT  = 0;
  localparam int SL_B0H  = 1;
  localparam int SL_B0L  = 2;
  localparam int SL_B1H  = 3;
  localparam int SL_B1L  = 4;
  localparam int SL_B2H  = 5;
  localparam int SL_B2L  = 6;
  localparam int SL_IRQ  = 7;
  localparam int SL_ITYP = 8;
  localparam int SL_DRX  = 9;
  localparam int SL_DTX  = 10;
  localparam int SL_MODE = 11;

  typedef enum logic [1:0] {
    KS_LOCKED = 2'd0,
    KS_HALF   = 2'd1,
    KS_OPEN   = 2'd2
  } key_state_t;

  // returns {valid, slot} for a banked index
  function automatic logic [SLOT_W:0] slot_decode(input logic [7:0] idx);
    logic [SLOT_W:0] r;
    case (idx)
      8'h30:   r = {1'b1, SLOT_W'(SL_ACT)};
      8'h60:   r = {1'b1, SLOT_W'(SL_B0H)};
      8'h61:   r = {1'b1, SLOT_W'(SL_B0L)};
      8'h62:   r = {1'b1, SLOT_W'(SL_B1H)};
      8'h63:   r = {1'b1, SLOT_W'(SL_B1L)};
      8'h64:   r = {1'b1, SLOT_W'(SL_B2H)};
      8'h65:   r = {1'b1, SLOT_W'(SL_B2L)};
      8'h70:   r = {1'b1, SLOT_W'(SL_IRQ)};
      8'h71:   r = {1'b1, SLOT_W'(SL_ITYP)};
      8'h74:   r = {1'b1, SLOT_W'(SL_DRX)};
      8'h75:   r = {1'b1, SLOT_W'(SL_DTX)};
      8'hF0:   r = {1'b1, SLOT_W'(SL_MODE)};
      default: r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cfg_key_fsm.sv
module cfg_key_fsm
  import cfg_gate_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       idx_wr,
  input  logic       dat_wr,
  input  logic [7:0] wdata,
  output logic       unlocked,
  output logic       idx_load,
  output logic       exit_hit
);

  key_state_t st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= KS_LOCKED;
    end else if (idx_wr) begin
      case (st_q)
        KS_LOCKED: st_q <= (wdata == KEY_ENTER) ? KS_HALF : KS_LOCKED;
        KS_HALF:   st_q <= (wdata == KEY_ENTER) ? KS_OPEN : KS_LOCKED;
        KS_OPEN:   st_q <= (wdata == KEY_EXIT)  ? KS_LOCKED : KS_OPEN;
        default:   st_q <= KS_LOCKED;
      endcase
    end else if (dat_wr && st_q == KS_HALF) begin
      st_q <= KS_LOCKED;
    end
  end

  assign unlocked = (st_q == KS_OPEN);
  assign exit_hit = unlocked && idx_wr && (wdata == KEY_EXIT);
  assign idx_load = unlocked && idx_wr && (wdata != KEY_EXIT);

endmodule

// File: rtl/cfg_global_regs.sv
module cfg_global_regs #(
  parameter int GLB_N = 16,
  localparam int AW = $clog2(GLB_N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [7:0]       wdata,
  output logic [GLB_N*8-1:0] regs
);

  for (genvar k = 0; k < GLB_N; k++) begin : g_reg
    localparam logic [AW-1:0] MY_ADDR = AW'(k);
    always_ff @(posedge clk) begin
      if (rst)                          regs[k*8 +: 8] <= 8'h00;
      else if (wr_en && addr == MY_ADDR) regs[k*8 +: 8] <= wdata;
    end
  end

endmodule

// File: rtl/cfg_ldev_bank.sv
module cfg_ldev_bank
  import cfg_gate_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [SLOT_W-1:0]     slot,
  input  logic [7:0]            wdata,
  output logic [SLOT_N*8-1:0]   regs
);

  for (genvar s = 0; s < SLOT_N; s++) begin : g_slot
    localparam logic [SLOT_W-1:0] MY_SLOT = SLOT_W'(s);
    if (s == SL_ACT) begin : g_act
      always_ff @(posedge clk) begin
        if (rst)                          regs[s*8 +: 8] <= 8'h00;
        else if (wr_en && slot == MY_SLOT) regs[s*8 +: 8] <= {7'b0, wdata[0]};
      end
    end else begin : g_byte
      always_ff @(posedge clk) begin
        if (rst)                          regs[s*8 +: 8] <= 8'h00;
        else if (wr_en && slot == MY_SLOT) regs[s*8 +: 8] <= wdata;
      end
    end
  end

endmodule

// File: rtl/keyed_cfg_port.sv
module keyed_cfg_port
  import cfg_gate_pkg::*;
#(
  parameter int NUM_LDEV = 10,
  parameter int GLB_N    = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    bus_addr,
  input  logic                    bus_wr,
  input  logic                    bus_rd,
  input  logic [7:0]              bus_wdata,
  output logic [7:0]              bus_rdata,
  output logic                    cfg_unlocked,
  output logic [NUM_LDEV-1:0]     dev_enable,
  output logic [NUM_LDEV*16-1:0]  dev_base0,
  output logic [NUM_LDEV*16-1:0]  dev_base1,
  output logic [NUM_LDEV*16-1:0]  dev_base2,
  output logic [NUM_LDEV*8-1:0]   dev_irq,
  output logic [NUM_LDEV*8-1:0]   dev_irq_type,
  output logic [NUM_LDEV*8-1:0]   dev_dma_rx,
  output logic [NUM_LDEV*8-1:0]   dev_dma_tx,
  output logic [NUM_LDEV*8-1:0]   dev_mode,
  output logic [GLB_N*8-1:0]      glb_regs
);

  localparam int GA_W    = $clog2(GLB_N);
  localparam int GLB_END = GLB_BASE + GLB_N;

  logic idx_wr, dat_wr;
  logic unlocked, idx_load, exit_hit;
  logic [7:0] idx_q, ldn_q;
  logic [SLOT_W-1:0] slot;
  logic slot_ok, dev_ok, glb_hit;
  logic [7:0] glb_off;
  logic [7:0] rd_val;
  logic [SLOT_N*8-1:0] bank_q [NUM_LDEV];
  logic [SLOT_N*8-1:0] bank_sel;

  assign idx_wr = bus_wr && !bus_addr;
  assign dat_wr = bus_wr &&  bus_addr;

  cfg_key_fsm u_key (
    .clk      (clk),
    .rst      (rst),
    .idx_wr   (idx_wr),
    .dat_wr   (dat_wr),
    .wdata    (bus_wdata),
    .unlocked (unlocked),
    .idx_load (idx_load),
    .exit_hit (exit_hit)
  );

  assign cfg_unlocked = unlocked;

  // index register
  always_ff @(posedge clk) begin
    if (rst || exit_hit) idx_q <= 8'h00;
    else if (idx_load)   idx_q <= bus_wdata;
  end

  // logical-device number
  always_ff @(posedge clk) begin
    if (rst)                                         ldn_q <= 8'h00;
    else if (unlocked && dat_wr && idx_q == IDX_LDN) ldn_q <= bus_wdata;
  end

  assign {slot_ok, slot} = slot_decode(idx_q);
  assign dev_ok  = 32'(ldn_q) < NUM_LDEV;
  assign glb_hit = (32'(idx_q) >= GLB_BASE) && (32'(idx_q) < GLB_END);
  assign glb_off = idx_q - 8'(GLB_BASE);

  cfg_global_regs #(.GLB_N(GLB_N)) u_glb (
    .clk   (clk),
    .rst   (rst),
    .wr_en (unlocked && dat_wr && glb_hit),
    .addr  (glb_off[GA_W-1:0]),
    .wdata (bus_wdata),
    .regs  (glb_regs)
  );

  for (genvar d = 0; d < NUM_LDEV; d++) begin : g_dev
    localparam logic [7:0] DEV_ID = 8'(d);
    cfg_ldev_bank u_bank (
      .clk   (clk),
      .rst   (rst),
      .wr_en (unlocked && dat_wr && slot_ok && ldn_q == DEV_ID),
      .slot  (slot),
      .wdata (bus_wdata),
      .regs  (bank_q[d])
    );
    assign dev_enable[d]          = bank_q[d][SL_ACT*8];
    assign dev_base0[d*16 +: 16]  = {bank_q[d][SL_B0H*8 +: 8], bank_q[d][SL_B0L*8 +: 8]};
    assign dev_base1[d*16 +: 16]  = {bank_q[d][SL_B1H*8 +: 8], bank_q[d][SL_B1L*8 +: 8]};
    assign dev_base2[d*16 +: 16]  = {bank_q[d][SL_B2H*8 +: 8], bank_q[d][SL_B2L*8 +: 8]};
    assign dev_irq[d*8 +: 8]      = bank_q[d][SL_IRQ*8 +: 8];
    assign dev_irq_type[d*8 +: 8] = bank_q[d][SL_ITYP*8 +: 8];
    assign dev_dma_rx[d*8 +: 8]   = bank_q[d][SL_DRX*8 +: 8];
    assign dev_dma_tx[d*8 +: 8]   = bank_q[d][SL_DTX*8 +: 8];
    assign dev_mode[d*8 +: 8]     = bank_q[d][SL_MODE*8 +: 8];
  end

  // read path
  always_comb begin
    bank_sel = '1;
    for (int d = 0; d < NUM_LDEV; d++) begin
      if (ldn_q == 8'(d)) bank_sel = bank_q[d];
    end
    rd_val = 8'hFF;
    if (idx_q == IDX_LDN)      rd_val = ldn_q;
    else if (glb_hit)          rd_val = glb_regs[{glb_off[GA_W-1:0], 3'b000} +: 8];
    else if (slot_ok && dev_ok) rd_val = bank_sel[{slot, 3'b000} +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst)              bus_rdata <= 8'hFF;
    else if (bus_rd) begin
      if (!unlocked)      bus_rdata <= 8'hFF;
      else if (bus_addr)  bus_rdata <= rd_val;
      else                bus_rdata <= idx_q;
    end
  end

  logic unused_ok;
  assign unused_ok = ^{glb_off};

endmodule

// File: rtl/cfg_gate_chk.sv
module cfg_gate_chk #(
  parameter int NUM_LDEV = 10
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  bus_addr,
  input logic                  bus_wr,
  input logic                  bus_rd,
  input logic [7:0]            bus_wdata,
  input logic [7:0]            bus_rdata,
  input logic                  cfg_unlocked,
  input logic [NUM_LDEV-1:0]   dev_enable,
  input logic [NUM_LDEV*8-1:0] dev_irq,
  input logic [NUM_LDEV*8-1:0] dev_mode
);

  // R2: opening always follows an entry-key byte on the index port
  a_r2_open_after_key: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_unlocked) |-> $past(bus_wr && !bus_addr && bus_wdata == 8'h87));

  // R4: exit key closes the gate
  a_r4_exit_closes: assert property (@(posedge clk) disable iff (rst)
    (cfg_unlocked && bus_wr && !bus_addr && bus_wdata == 8'hAA) |=> !cfg_unlocked);

  // R3: while locked the device setup cannot move
  a_r3_locked_frozen: assert property (@(posedge clk) disable iff (rst)
    !cfg_unlocked |=> ($stable(dev_enable) && $stable(dev_irq) && $stable(dev_mode)));

  // R6: enables change only after an open data-port write
  a_r6_enable_by_write: assert property (@(posedge clk) disable iff (rst)
    !$stable(dev_enable) |-> $past(bus_wr && bus_addr && cfg_unlocked));

  // R11: read data holds without a read strobe
  a_r11_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_rd) |-> $stable(bus_rdata));

  // R11: one access per cycle (input assumption)
  a_r11_one_strobe: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && bus_wr));

endmodule

bind keyed_cfg_port cfg_gate_chk #(.NUM_LDEV(NUM_LDEV)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .bus_addr     (bus_addr),
  .bus_wr       (bus_wr),
  .bus_rd       (bus_rd),
  .bus_wdata    (bus_wdata),
  .bus_rdata    (bus_rdata),
  .cfg_unlocked (cfg_unlocked),
  .dev_enable   (dev_enable),
  .dev_irq      (dev_irq),
  .dev_mode     (dev_mode)
);

// File: tb/keyed_cfg_port_tb.sv
module keyed_cfg_port_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NDEV = 10;
  localparam int NGLB = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_addr = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic cfg_unlocked;
  logic [NDEV-1:0] dev_enable;
  logic [NDEV*16-1:0] dev_base0, dev_base1, dev_base2;
  logic [NDEV*8-1:0] dev_irq, dev_irq_type, dev_dma_rx, dev_dma_tx, dev_mode;
  logic [NGLB*8-1:0] glb_regs;

  always #(CLK_PERIOD/2) clk = ~clk;

  keyed_cfg_port #(.NUM_LDEV(NDEV), .GLB_N(NGLB)) dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg_unlocked(cfg_unlocked),
    .dev_enable(dev_enable), .dev_base0(dev_base0), .dev_base1(dev_base1),
    .dev_base2(dev_base2), .dev_irq(dev_irq), .dev_irq_type(dev_irq_type),
    .dev_dma_rx(dev_dma_rx), .dev_dma_tx(dev_dma_tx), .dev_mode(dev_mode),
    .glb_regs(glb_regs)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference model
  int         m_st;      // 0 locked, 1 half key, 2 open
  logic [7:0] m_idx, m_ldn;
  logic [7:0] m_glb [NGLB];
  logic [7:0] m_dv  [NDEV][12];

  function automatic int slot_of(input logic [7:0] i);
    case (i)
      8'h30: return 0;  8'h60: return 1;  8'h61: return 2;  8'h62: return 3;
      8'h63: return 4;  8'h64: return 5;  8'h65: return 6;  8'h70: return 7;
      8'h71: return 8;  8'h74: return 9;  8'h75: return 10; 8'hF0: return 11;
      default: return -1;
    endcase
  endfunction

  function automatic logic [7:0] exp_read(input logic a);
    int s;
    if (m_st != 2) return 8'hFF;
    if (!a) return m_idx;
    if (m_idx == 8'h07) return m_ldn;
    if (m_idx >= 8'h20 && m_idx < 8'h20 + NGLB) return m_glb[m_idx - 8'h20];
    s = slot_of(m_idx);
    if (s >= 0 && int'(m_ldn) < NDEV) return m_dv[m_ldn][s];
    return 8'hFF;
  endfunction

  task automatic model_reset();
    m_st = 0; m_idx = 0; m_ldn = 0;
    for (int k = 0; k < NGLB; k++) m_glb[k] = 0;
    for (int d = 0; d < NDEV; d++) for (int s = 0; s < 12; s++) m_dv[d][s] = 0;
  endtask

  task automatic model_write(input logic a, input logic [7:0] v);
    int s;
    if (!a) begin
      case (m_st)
        0: m_st = (v == 8'h87) ? 1 : 0;
        1: m_st = (v == 8'h87) ? 2 : 0;
        default: if (v == 8'hAA) begin m_st = 0; m_idx = 0; end else m_idx = v;
      endcase
    end else if (m_st == 1) begin
      m_st = 0;
    end else if (m_st == 2) begin
      s = slot_of(m_idx);
      if (m_idx == 8'h07) m_ldn = v;
      else if (m_idx >= 8'h20 && m_idx < 8'h20 + NGLB) m_glb[m_idx - 8'h20] = v;
      else if (s >= 0 && int'(m_ldn) < NDEV) m_dv[m_ldn][s] = (s == 0) ? {7'b0, v[0]} : v;
    end
  endtask

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] v);
    @(negedge clk);
    bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    model_write(a, v);
  endtask

  task automatic rd_chk(input logic a, input string tag);
    logic [7:0] e;
    e = exp_read(a);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    chk(bus_rdata == e, tag, 64'(bus_rdata), 64'(e));
  endtask

  task automatic set_reg(input logic [7:0] i, input logic [7:0] v);
    wr(1'b0, i); wr(1'b1, v);
  endtask

  task automatic check_outs();
    for (int d = 0; d < NDEV; d++) begin
      chk(dev_enable[d] == m_dv[d][0][0], "R6 dev_enable", 64'(dev_enable[d]), 64'(m_dv[d][0][0]));
      chk({dev_base0[d*16 +: 16], dev_base1[d*16 +: 16], dev_base2[d*16 +: 16]} ==
          {m_dv[d][1], m_dv[d][2], m_dv[d][3], m_dv[d][4], m_dv[d][5], m_dv[d][6]},
          "R7 base addresses",
          64'({dev_base0[d*16 +: 16], dev_base1[d*16 +: 16], dev_base2[d*16 +: 16]}),
          64'({m_dv[d][1], m_dv[d][2], m_dv[d][3], m_dv[d][4], m_dv[d][5], m_dv[d][6]}));
      chk({dev_irq[d*8 +: 8], dev_irq_type[d*8 +: 8], dev_dma_rx[d*8 +: 8], dev_dma_tx[d*8 +: 8], dev_mode[d*8 +: 8]} ==
          {m_dv[d][7], m_dv[d][8], m_dv[d][9], m_dv[d][10], m_dv[d][11]},
          "R8 irq/dma/mode",
          64'({dev_irq[d*8 +: 8], dev_irq_type[d*8 +: 8], dev_dma_rx[d*8 +: 8], dev_dma_tx[d*8 +: 8], dev_mode[d*8 +: 8]}),
          64'({m_dv[d][7], m_dv[d][8], m_dv[d][9], m_dv[d][10], m_dv[d][11]}));
    end
    for (int k = 0; k < NGLB; k++)
      chk(glb_regs[k*8 +: 8] == m_glb[k], "R9 global output", 64'(glb_regs[k*8 +: 8]), 64'(m_glb[k]));
  endtask

  function automatic logic [7:0] pick_idx();
    logic [7:0] lst [18] = '{8'h07, 8'h20, 8'h22, 8'h26, 8'h2A, 8'h2F, 8'h30, 8'h60, 8'h61,
                             8'h62, 8'h63, 8'h64, 8'h65, 8'h70, 8'h71, 8'h74, 8'h75, 8'hF0};
    int r = int'($urandom % 24);
    if (r < 18) return lst[r];
    return 8'($urandom);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] held;
    void'($urandom(32'd4242));
    model_reset();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk(bus_rdata == 8'hFF, "R1 rdata after reset", 64'(bus_rdata), 64'hFF);
    chk(cfg_unlocked == 1'b0, "R1 locked after reset", 64'(cfg_unlocked), 64'h0);
    check_outs();

    // R3 locked: writes ignored, reads idle
    wr(1'b0, 8'h07); wr(1'b1, 8'h05);
    rd_chk(1'b1, "R3 locked data read");
    rd_chk(1'b0, "R3 locked index read");

    // R2 broken keys
    wr(1'b0, 8'h87); wr(1'b0, 8'h55); wr(1'b0, 8'h87);
    chk(cfg_unlocked == 1'b0, "R2 key broken by index write", 64'(cfg_unlocked), 64'h0);
    rd_chk(1'b0, "R2 still locked");
    wr(1'b0, 8'hAA);                  // half key -> locked
    wr(1'b0, 8'h87); wr(1'b1, 8'h11); wr(1'b0, 8'h87);
    chk(cfg_unlocked == 1'b0, "R2 key broken by data write", 64'(cfg_unlocked), 64'h0);
    wr(1'b0, 8'hAA);
    wr(1'b0, 8'h87); wr(1'b0, 8'h87);
    chk(cfg_unlocked == 1'b1, "R2 open after key", 64'(cfg_unlocked), 64'h1);
    rd_chk(1'b0, "R4 index read after open");
    wr(1'b0, 8'h07);
    rd_chk(1'b1, "R3 locked write to ldn had no effect");

    // device 3 setup
    set_reg(8'h07, 8'h03);
    set_reg(8'h30, 8'hFF);
    rd_chk(1'b1, "R6 activate reads bit0 only");
    set_reg(8'h60, 8'h12); set_reg(8'h61, 8'h34);
    set_reg(8'h64, 8'hAB); set_reg(8'h65, 8'hCD);
    set_reg(8'h70, 8'h0A); set_reg(8'h71, 8'h02);
    set_reg(8'h74, 8'h00); set_reg(8'h75, 8'h04);
    set_reg(8'hF0, 8'h03);
    chk(dev_base0[3*16 +: 16] == 16'h1234, "R7 base0 high/low order", 64'(dev_base0[3*16 +: 16]), 64'h1234);
    chk(dev_enable == NDEV'(1 << 3), "R6 only device 3 enabled", 64'(dev_enable), 64'(1 << 3));
    check_outs();

    // R5 other device untouched
    set_reg(8'h07, 8'h04);
    wr(1'b0, 8'h70);
    rd_chk(1'b1, "R5 device 4 irq still zero");

    // R9 global shared
    set_reg(8'h26, 8'h40);
    set_reg(8'h07, 8'h00);
    wr(1'b0, 8'h26);
    rd_chk(1'b1, "R9 global seen from other device");

    // R10 unimplemented index and out-of-range device
    set_reg(8'h10, 8'h5A);
    rd_chk(1'b1, "R10 unimplemented index reads FF");
    set_reg(8'h07, 8'h0C);
    set_reg(8'h30, 8'h01);
    rd_chk(1'b1, "R10 banked read with device out of range");
    chk(dev_enable == NDEV'(1 << 3), "R10 out-of-range write ignored", 64'(dev_enable), 64'(1 << 3));

    // R11 read data hold
    wr(1'b0, 8'h71);
    rd_chk(1'b0, "R11 index read");
    held = bus_rdata;
    wr(1'b0, 8'h62);
    repeat (3) @(negedge clk);
    chk(bus_rdata == held, "R11 rdata holds without strobe", 64'(bus_rdata), 64'(held));

    // R4 exit
    wr(1'b0, 8'hAA);
    chk(cfg_unlocked == 1'b0, "R4 exit key locks", 64'(cfg_unlocked), 64'h0);
    rd_chk(1'b1, "R4 data read after exit");
    wr(1'b0, 8'h87); wr(1'b0, 8'h87);
    rd_chk(1'b0, "R4 index cleared on exit");

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      int op = int'($urandom % 100);
      if (op < 4)       wr(1'b0, 8'hAA);
      else if (op < 9)  begin wr(1'b0, 8'h87); wr(1'b0, 8'h87); end
      else if (op < 11) wr(1'b0, 8'h87);
      else if (op < 40) wr(1'b0, pick_idx());
      else if (op < 70) wr(1'b1, (m_idx == 8'h07) ? 8'($urandom % 12) : 8'($urandom));
      else if (op < 90) rd_chk(1'b1, "R5 random data read");
      else              rd_chk(1'b0, "R4 random index read");
      if (n % 500 == 499) check_outs();
    end
    check_outs();

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule